// File: doc/BRIEF.md
# Packet-Aware Stream Width Converter

This block turns a valid/ready stream of one payload width into a valid/ready stream of another width. The new width may be narrower or wider, and the two widths need not divide each other. The bits leave in the order they arrived. The lowest bits of each input word go out first. The block treats the input as one continuous bitstream and cuts it into output words.

Each input word may carry a packet-end flag. That flag stays with the bit that ended the flagged word. The output word holding that bit is the one that carries the end flag.

When the input width is a whole multiple of the output width, a plain slicer is built instead of the general shifter. The slicer holds one word and shifts it down one slice at a time. Both variants produce the same output stream.

Top module: `stream_regear`

## Requirements
- R1: The output bitstream equals the concatenated input bitstream, with bit 0 of each input word first and bit 0 of each output word holding the earliest bit. This holds for any pair of widths, including pairs that do not divide.
- R2: With 8-bit input and 4-bit output, input 0x21 flagged last followed by input 0x84 unflagged gives 0x1 (last=0), then 0x2 (last=1), then 0x4 (last=0), then 0x8 (last=0).
- R3: An output word carries last exactly when it contains the final bit of at least one flagged input word. When the output is wider, two such ends that land in one output word produce a single last on that word. The same word may also hold bits of the following input word.
- R4: For an input width six times the output width, each input word gives six output words, and only the sixth carries that input's last.
- R5: No last is lost under backpressure. With 16-bit input and 4-bit output, 50 input words with every fifth one flagged (starting with the first), and random stalls on both sides, exactly 10 output words carry last.
- R6: in_ready is high only when the held bits plus one more input word fit in the residual register. In particular, in_ready is always high while out_valid is low.
- R7: While out_valid is high and out_ready is low, out_valid, out_data and out_last stay unchanged.
- R8: After reset, out_valid is low and in_ready is high.
- R9: When the input width is a whole multiple of the output width, a slicer variant is used. It gives the same stream as R1 to R5, and it can accept a new word in the same cycle the last slice of the held word is taken.
- R10: Leftover bits that do not fill an output word are held, never padded or flushed. out_valid stays low until later input completes the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word can be taken this cycle |
| in_data | input | IN_W | Input payload, bit 0 goes out first |
| in_last | input | 1 | Input word ends a packet |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | OUT_W | Output payload |
| out_last | output | 1 | Output word holds the end of a packet |

## Verification
Two things can happen in the same cycle: an output word is popped from the residual register, and a new input word is appended behind the remaining bits. This is possible because in_ready also looks at out_ready when the register holds a full word but not yet two. Independent random stalls on in_valid and out_ready make these two events coincide many times for six width pairs. Both integer and non-integer ratios are covered, in both directions.

A bit-level scoreboard judges every output word. The scoreboard keeps a queue of input bits, each tagged with whether it ended a flagged word. It pops exactly one output width of bits per accepted output and compares both the payload and the OR of the end tags.

// File: rtl/stream_regear.sv
module stream_regear #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data,
  output logic             out_last
);

  localparam bit SLICER = (IN_W >= OUT_W) && (IN_W % OUT_W == 0);

  logic pop, push;
  assign pop  = out_valid & out_ready;
  assign push = in_valid & in_ready;

  generate
    if (SLICER) begin : g_slice
      localparam int RATIO = IN_W / OUT_W;
      localparam int KW    = (RATIO > 1) ? $clog2(RATIO) : 1;

      logic [IN_W-1:0] word_q;
      logic            full_q, last_q;
      logic [KW-1:0]   k_q;
      logic            final_slice;

      assign final_slice = (k_q == KW'(RATIO - 1));
      assign out_valid   = full_q;
      assign out_data    = word_q[OUT_W-1:0];
      assign out_last    = last_q & final_slice;
      assign in_ready    = ~full_q | (out_ready & final_slice);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          word_q <= '0;
          full_q <= 1'b0;
          last_q <= 1'b0;
          k_q    <= '0;
        end else if (push) begin
          word_q <= in_data;
          full_q <= 1'b1;
          last_q <= in_last;
          k_q    <= '0;
        end else if (pop) begin
          if (final_slice) begin
            full_q <= 1'b0;
          end else begin
            word_q <= word_q >> OUT_W;
            k_q    <= k_q + 1'b1;
          end
        end
      end
    end else begin : g_shift
      localparam int BUF_W = IN_W + OUT_W - 1;
      localparam int CW    = $clog2(BUF_W + 1);

      logic [BUF_W-1:0] data_q, mark_q, data_base, mark_base, data_d, mark_d;
      logic [CW-1:0]    cnt_q, cnt_base, cnt_d;

      assign out_valid = (32'(cnt_q) >= OUT_W);
      assign out_data  = data_q[OUT_W-1:0];
      assign out_last  = |mark_q[OUT_W-1:0];
      assign in_ready  = (32'(cnt_q) < OUT_W) ||
                         ((32'(cnt_q) < 2 * OUT_W) && out_ready);

      assign data_base = pop ? (data_q >> OUT_W) : data_q;
      assign mark_base = pop ? (mark_q >> OUT_W) : mark_q;
      assign cnt_base  = pop ? (cnt_q - CW'(OUT_W)) : cnt_q;

      assign data_d = data_base |
                      (push ? (BUF_W'(in_data) << cnt_base) : '0);
      assign mark_d = mark_base |
                      ((push && in_last) ? (BUF_W'(1) << (cnt_base + CW'(IN_W - 1))) : '0);
      assign cnt_d  = cnt_base + (push ? CW'(IN_W) : '0);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          data_q <= '0;
          mark_q <= '0;
          cnt_q  <= '0;
        end else begin
          data_q <= data_d;
          mark_q <= mark_d;
          cnt_q  <= cnt_d;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/regear_props.sv
module regear_props #(
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data,
  input logic             out_last
);

  a_r7_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  a_r7_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_data) && $stable(out_last));

  a_r6_drained_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r8_reset_idle: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

endmodule

bind stream_regear regear_props #(.OUT_W(OUT_W)) u_props (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
);

// File: tb/test_stream_regear.sv
module regear_env #(
  parameter int IN_W = 8,
  parameter int OUT_W = 4,
  parameter int N_WORDS = 10,
  parameter int LAST_EVERY = 2,
  parameter bit USE_FIXED = 0,
  parameter logic [63:0] W0 = 64'h0,
  parameter logic [63:0] W1 = 64'h0,
  parameter int EXP_LASTS = -1,
  parameter string TAG = "R1"
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  logic             in_valid, in_ready, in_last, out_valid, out_ready, out_last;
  logic [IN_W-1:0]  in_data;
  logic [OUT_W-1:0] out_data;

  int checks, fails;
  bit qbits[$];
  bit qend[$];

  stream_regear #(.IN_W(IN_W), .OUT_W(OUT_W)) i_stream_regear (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  initial begin
    int sent, outs, lasts_out, guard;
    bit took, hold, r6_bad, r7_bad;
    logic [OUT_W-1:0] prev_data, expd;
    logic prev_last, expl;
    done = 0; checks = 0; fails = 0;
    in_valid = 0; in_last = 0; in_data = '0; out_ready = 0;
    sent = 0; outs = 0; lasts_out = 0; guard = 0;
    took = 0; hold = 0; r6_bad = 0; r7_bad = 0;
    prev_data = '0; prev_last = 0;
    wait (rst_n === 1'b1);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R8 %s: out_valid=%b in_ready=%b, expected 0 1", TAG, out_valid, in_ready);
    end
    while (!(sent == N_WORDS && !in_valid && qbits.size() < OUT_W) && guard < 20000) begin
      guard++;
      if (took) begin in_valid = 0; in_last = 0; took = 0; end
      if (!in_valid && sent < N_WORDS && ($urandom % 10) < 7) begin
        logic [IN_W-1:0] w;
        for (int j = 0; j < IN_W; j++) w[j] = 1'($urandom % 2);
        if (USE_FIXED && sent == 0) w = IN_W'(W0);
        if (USE_FIXED && sent == 1) w = IN_W'(W1);
        in_data = w;
        in_last = ((sent % LAST_EVERY) == 0);
        in_valid = 1;
        sent++;
      end
      out_ready = (($urandom % 10) < 7);
      #4;
      if (!out_valid && !in_ready) r6_bad = 1;
      if (hold && (!out_valid || out_data !== prev_data || out_last !== prev_last)) r7_bad = 1;
      hold = out_valid && !out_ready;
      prev_data = out_data; prev_last = out_last;
      if (out_valid && out_ready) begin
        checks++;
        if (qbits.size() < OUT_W) begin
          fails++;
          $display("FAIL R1 %s: unexpected word %h, expected none", TAG, out_data);
        end else begin
          expd = '0; expl = 0;
          for (int j = 0; j < OUT_W; j++) begin
            expd[j] = qbits.pop_front();
            expl = expl | qend.pop_front();
          end
          if (out_data !== expd || out_last !== expl) begin
            fails++;
            $display("FAIL %s word %0d: data=%h last=%b, expected data=%h last=%b",
                     TAG, outs, out_data, out_last, expd, expl);
          end
        end
        if (TAG == "R2/R9" && outs < 2) begin
          checks++;
          if (out_data !== OUT_W'(outs == 0 ? 1 : 2) || out_last !== (outs == 1)) begin
            fails++;
            $display("FAIL R2 word %0d: data=%h last=%b, expected data=%h last=%b",
                     outs, out_data, out_last, (outs == 0 ? 1 : 2), (outs == 1));
          end
        end
        if (out_last) lasts_out++;
        outs++;
      end
      if (in_valid && in_ready) begin
        for (int j = 0; j < IN_W; j++) begin
          qbits.push_back(in_data[j]);
          qend.push_back(in_last && j == IN_W - 1);
        end
        took = 1;
      end
      @(negedge clk);
    end
    if (took) begin in_valid = 0; in_last = 0; end
    out_ready = 1;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R10 %s: out_valid=%b with %0d bits held, expected 0", TAG, out_valid, qbits.size());
    end
    checks++;
    if (r6_bad) begin
      fails++;
      $display("FAIL R6 %s: in_ready=0 while out_valid=0, expected 1", TAG);
    end
    checks++;
    if (r7_bad) begin
      fails++;
      $display("FAIL R7 %s: output changed under backpressure, expected stable", TAG);
    end
    if (EXP_LASTS >= 0) begin
      checks++;
      if (lasts_out != EXP_LASTS) begin
        fails++;
        $display("FAIL %s last count: %0d, expected %0d", TAG, lasts_out, EXP_LASTS);
      end
    end
    done = 1;
  end
endmodule

module test_stream_regear;
  localparam int CLK_PERIOD = 10;
  logic clk = 0;
  logic rst_n = 0;
  logic d_a, d_b, d_c, d_d, d_e, d_f;
  int total_checks, total_fails;

  always #(CLK_PERIOD / 2) clk = ~clk;

  regear_env #(.IN_W(8), .OUT_W(4), .N_WORDS(20), .LAST_EVERY(2), .USE_FIXED(1),
               .W0(64'h21), .W1(64'h84), .TAG("R2/R9")) e_a (.clk(clk), .rst_n(rst_n), .done(d_a));
  regear_env #(.IN_W(16), .OUT_W(4), .N_WORDS(50), .LAST_EVERY(5), .EXP_LASTS(10),
               .TAG("R5/R9")) e_b (.clk(clk), .rst_n(rst_n), .done(d_b));
  regear_env #(.IN_W(48), .OUT_W(8), .N_WORDS(12), .LAST_EVERY(1), .EXP_LASTS(12),
               .TAG("R4/R9")) e_c (.clk(clk), .rst_n(rst_n), .done(d_c));
  regear_env #(.IN_W(12), .OUT_W(8), .N_WORDS(30), .LAST_EVERY(3),
               .TAG("R1")) e_d (.clk(clk), .rst_n(rst_n), .done(d_d));
  regear_env #(.IN_W(4), .OUT_W(12), .N_WORDS(30), .LAST_EVERY(2),
               .TAG("R3/R1")) e_e (.clk(clk), .rst_n(rst_n), .done(d_e));
  regear_env #(.IN_W(8), .OUT_W(12), .N_WORDS(7), .LAST_EVERY(3),
               .TAG("R10")) e_f (.clk(clk), .rst_n(rst_n), .done(d_f));

  initial begin
    bit timed_out;
    timed_out = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    fork
      wait (d_a && d_b && d_c && d_d && d_e && d_f);
      begin repeat (100000) @(negedge clk); timed_out = 1; end
    join_any
    total_checks = e_a.checks + e_b.checks + e_c.checks + e_d.checks + e_e.checks + e_f.checks;
    total_fails  = e_a.fails + e_b.fails + e_c.fails + e_d.fails + e_e.fails + e_f.fails;
    if (timed_out) begin
      total_checks++;
      total_fails++;
      $display("FAIL watchdog: run incomplete, expected all streams drained");
    end
    $display("TB_RESULT checks=%0d failures=%0d", total_checks, total_fails);
    $finish;
  end
endmodule